// File: doc/BRIEF.md
# Single-to-Brain-Float Narrowing Unit

This unit narrows 32-bit IEEE single-precision words into 16-bit brain-float words: one sign bit, the full 8-bit exponent and the top 7 mantissa bits. It sits in a streaming datapath. A producer offers a word with `in_valid`, and the unit takes it whenever `in_ready` is high. One cycle later the narrowed word appears on `out_half` with `out_valid` raised. `out_nan` is a side flag that marks results which came from a NaN.

Finite values, zeros, subnormals and infinities all go through one rounding path. That path rounds to the nearest representable value and breaks exact ties toward an even last bit. A finite value that rounds beyond the largest finite number becomes an infinity of the same sign. A NaN skips rounding entirely. Its sign and upper payload bits are kept, and its top mantissa bit is forced to one so the result is always a quiet NaN.

The output register is a one-entry slot driven by a two-state machine:
- `SLOT_EMPTY`: nothing is held.
- `SLOT_FULL`: a result is held until the consumer takes it.

The machine has these transitions:
- *fill*: EMPTY to FULL on an accepted input.
- *refill*: FULL to FULL when an input is accepted in the same cycle the held result is read.
- *hold*: FULL to FULL when the held result is not read.
- *drain*: FULL to EMPTY when the result is read and no input arrives.
- *idle*: EMPTY to EMPTY when no input arrives.

Top module: `bf16_narrow`

## Requirements
- R1: A synchronous active-high `rst` forces the slot to SLOT_EMPTY, so `out_valid` is low in the cycle after any clock edge where `rst` was high.
- R2: An input accepted at a clock edge (`in_valid` and `in_ready` both high) is presented on `out_valid`/`out_half`/`out_nan` right after that same edge, a latency of one cycle.
- R3: `in_ready` is high exactly when the slot is empty or `out_ready` is high in the same cycle.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_half` and `out_nan` keep their values across the clock edge.
- R5: An input x is a NaN exactly when (x AND 0x7FFFFFFF) > 0x7F800000, compared as unsigned. `out_nan` is 1 for such inputs and 0 for all others.
- R6: For a NaN input the result is x[31:16] OR 0x0040, with bit 6 being the top mantissa bit. For example, 0x7F800001 gives 0x7FC0 and 0xFFC12345 gives 0xFFC1.
- R7: For a non-NaN input with retained half H = x[31:16] and discarded half L = x[15:0], the result is H+1 when L > 0x8000, or when L = 0x8000 and H is odd. Otherwise the result is H. Examples: 0x3F800000 gives 0x3F80, 0x41200000 gives 0x4120, 0x3F808000 gives 0x3F80, and 0x3F818000 gives 0x3F82. The sign bit of the result always equals x[31].
- R8: Infinities are not NaNs and pass unchanged: 0x7F800000 gives 0x7F80 and 0xFF800000 gives 0xFF80.
- R9: A finite value that rounds past the largest finite magnitude becomes an infinity of its own sign: 0x7F7FFFFF gives 0x7F80 and 0xFF7FFFFF gives 0xFF80.
- R10: Zeros and subnormals are rounded without flushing. 0x80000000 gives 0x8000, 0x00008000 gives 0x0000, 0x00008001 gives 0x0001, and 0x00018000 gives 0x0002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers `in_word` |
| in_word | input | 32 | Single-precision input word |
| in_ready | output | 1 | Unit can take a word this cycle |
| out_valid | output | 1 | `out_half` holds a result |
| out_half | output | 16 | Brain-float result |
| out_nan | output | 1 | Result came from a NaN input |
| out_ready | input | 1 | Consumer takes the result this cycle |

## Verification
The hardest situation to reach from the ports is the *refill* transition. It needs a result held in the slot, the consumer reading it, and a new word arriving in the same cycle. That word also has to be a rounding corner, such as an exact tie, a carry into the exponent or a signalling NaN. Neither random ready patterns alone nor purely random words reliably produce all of that together. The stimulus therefore toggles `in_valid` and `out_ready` independently at random on every cycle. Its word generator favours discarded halves near 0x8000, all-ones exponents, the largest finite exponent/mantissa combination and subnormals. A reset is also applied while the slot is full, to confirm that a held result is discarded.

// File: rtl/bf16n_pkg.sv
package bf16n_pkg;

    // One-entry output slot states
    typedef enum logic [0:0] {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

endpackage

// File: rtl/bf16n_classify.sv
module bf16n_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] word,
    output logic                 is_nan
);
    localparam int IN_W  = 1 + EXP_W + MAN_W;
    localparam int MAG_W = IN_W - 1;

    // Largest non-NaN magnitude: all-ones exponent, zero mantissa (infinity)
    localparam logic [MAG_W-1:0] INF_MAG = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};

    logic [MAG_W-1:0] magnitude;

    always_comb begin
        magnitude = word[MAG_W-1:0];
        is_nan    = (magnitude > INF_MAG);
    end

endmodule

// File: rtl/bf16n_round.sv
module bf16n_round #(
    parameter int EXP_W    = 8,
    parameter int MAN_W    = 23,
    parameter int KEEP_MAN = 7
) (
    input  logic [EXP_W+MAN_W:0]    word,
    input  logic                    is_nan,
    output logic [EXP_W+KEEP_MAN:0] result
);
    localparam int IN_W  = 1 + EXP_W + MAN_W;
    localparam int OUT_W = 1 + EXP_W + KEEP_MAN;
    localparam int DROP  = MAN_W - KEEP_MAN;
    localparam int QUIET = KEEP_MAN - 1;

    // Half of one retained LSB, minus one: all ones across the discarded half but its top bit
    localparam logic [IN_W-1:0] HALF_MINUS = {{(IN_W-DROP+1){1'b0}}, {(DROP-1){1'b1}}};

    logic [IN_W-1:0]  bias;
    logic [IN_W-1:0]  biased;
    logic [OUT_W-1:0] nan_half;
    logic [OUT_W-1:0] num_half;

    generate
        if (KEEP_MAN > 0) begin : g_quiet
            always_comb nan_half = word[IN_W-1:DROP] | (OUT_W'(1) << QUIET);
        end else begin : g_noquiet
            always_comb nan_half = word[IN_W-1:DROP];
        end
    endgenerate

    always_comb begin
        // Retained LSB decides the tie: odd LSB pushes an exact half over
        bias     = HALF_MINUS + IN_W'(word[DROP]);
        biased   = word + bias;
        num_half = biased[IN_W-1:DROP];
        result   = is_nan ? nan_half : num_half;
    end

endmodule

// File: rtl/bf16n_slot.sv
module bf16n_slot
    import bf16n_pkg::*;
#(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_valid,
    input  logic [W-1:0] load_data,
    output logic         load_ready,
    input  logic         drain_ready,
    output logic         slot_valid,
    output logic [W-1:0] slot_data
);
    slot_state_e    state_q;
    slot_state_e    state_d;
    logic [W-1:0]   data_q;
    logic           load_fire;
    logic           drain_fire;

    always_comb begin
        load_ready = (state_q == SLOT_EMPTY) || drain_ready;
        load_fire  = load_valid && load_ready;
        drain_fire = (state_q == SLOT_FULL) && drain_ready;
    end

    // Next-state logic: fill, refill, hold, drain, idle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: state_d = load_fire ? SLOT_FULL : SLOT_EMPTY;
            SLOT_FULL: begin
                if (load_fire)       state_d = SLOT_FULL;
                else if (drain_fire) state_d = SLOT_EMPTY;
                else                 state_d = SLOT_FULL;
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SLOT_EMPTY;
        else     state_q <= state_d;
    end

    // Data register, written only on an accepted load
    always_ff @(posedge clk) begin
        if (load_fire) data_q <= load_data;
    end

    // Outputs
    always_comb begin
        slot_valid = (state_q == SLOT_FULL);
        slot_data  = data_q;
    end

    AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> !slot_valid); // R1
    AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        load_valid && load_ready |=> slot_valid && slot_data == $past(load_data)); // R2
    AST_READY_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !slot_valid |-> load_ready); // R3
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        slot_valid && !drain_ready |=> slot_valid && $stable(slot_data)); // R4

endmodule

// File: rtl/bf16_narrow.sv
module bf16_narrow #(
    parameter int EXP_W    = 8,
    parameter int MAN_W    = 23,
    parameter int KEEP_MAN = 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [EXP_W+MAN_W:0]     in_word,
    output logic                     in_ready,
    output logic                     out_valid,
    output logic [EXP_W+KEEP_MAN:0]  out_half,
    output logic                     out_nan,
    input  logic                     out_ready
);
    localparam int IN_W   = 1 + EXP_W + MAN_W;
    localparam int OUT_W  = 1 + EXP_W + KEEP_MAN;
    localparam int SLOT_W = OUT_W + 1;

    logic               word_nan;
    logic [OUT_W-1:0]   narrowed;
    logic [SLOT_W-1:0]  slot_out;

    bf16n_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_classify (
        .word   (in_word),
        .is_nan (word_nan)
    );

    bf16n_round #(.EXP_W(EXP_W), .MAN_W(MAN_W), .KEEP_MAN(KEEP_MAN)) u_round (
        .word   (in_word),
        .is_nan (word_nan),
        .result (narrowed)
    );

    bf16n_slot #(.W(SLOT_W)) u_slot (
        .clk         (clk),
        .rst         (rst),
        .load_valid  (in_valid),
        .load_data   ({word_nan, narrowed}),
        .load_ready  (in_ready),
        .drain_ready (out_ready),
        .slot_valid  (out_valid),
        .slot_data   (slot_out)
    );

    always_comb begin
        out_nan  = slot_out[SLOT_W-1];
        out_half = slot_out[OUT_W-1:0];
    end

    AST_NAN_QUIET: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_nan |-> out_half[KEEP_MAN-1] && (&out_half[OUT_W-2:KEEP_MAN])); // R6
    AST_NO_FAKE_NAN: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_nan |-> !((&out_half[OUT_W-2:KEEP_MAN]) && (|out_half[KEEP_MAN-1:0]))); // R7
    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_half[OUT_W-1] == $past(in_word[IN_W-1])); // R7
    AST_NAN_FLAG: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_nan == ($past(in_word[IN_W-2:0]) > {{EXP_W{1'b1}}, {MAN_W{1'b0}}})); // R5

endmodule

// File: tb/tb_bf16_narrow.sv
module tb_bf16_narrow;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_word;
    logic        in_ready;
    logic        out_valid;
    logic [15:0] out_half;
    logic        out_nan;
    logic        out_ready;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [48:0] q[$];        // {word, nan, expected half}
    logic        hold_pend = 1'b0;
    logic [16:0] held;

    always #5 clk = ~clk;

    bf16_narrow dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .out_valid(out_valid), .out_half(out_half),
        .out_nan(out_nan), .out_ready(out_ready)
    );

    // Behavioural reference: compare discarded half against one half-LSB
    function automatic logic [16:0] ref_conv(input logic [31:0] x);
        logic [15:0] hi;
        logic [15:0] lo;
        if (x[30:0] > 31'h7F800000) return {1'b1, x[31:16] | 16'h0040};
        hi = x[31:16];
        lo = x[15:0];
        if (lo > 16'h8000 || (lo == 16'h8000 && hi[0])) hi = hi + 16'd1;
        return {1'b0, hi};
    endfunction

    function automatic string tag_of(input logic [31:0] x);
        if (x[30:0] > 31'h7F800000) return "R6";
        if (x[30:0] == 31'h7F800000) return "R8";
        if (x[30:23] == 8'h00) return "R10";
        if (x[30:16] == 15'h7F7F) return "R9";
        return "R7";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    bit fired;

    task automatic step(input logic v, input logic [31:0] w, input logic r);
        logic [48:0] e;
        @(negedge clk);
        in_valid  = v;
        in_word   = w;
        out_ready = r;
        #1;
        check(out_valid == (q.size() != 0), "R2", "out_valid", 32'(out_valid), 32'(q.size() != 0));
        check(in_ready == (q.size() == 0 || r), "R3", "in_ready", 32'(in_ready), 32'(q.size() == 0 || r));
        if (hold_pend)
            check(out_valid && {out_nan, out_half} == held, "R4", "held result",
                  32'({out_nan, out_half}), 32'(held));
        if (out_valid && out_ready && q.size() != 0) begin
            e = q.pop_front();
            check(out_half == e[15:0], tag_of(e[48:17]), "result", 32'(out_half), 32'(e[15:0]));
            check(out_nan == e[16], "R5", "nan flag", 32'(out_nan), 32'(e[16]));
        end
        hold_pend = out_valid && !out_ready;
        held      = {out_nan, out_half};
        fired     = v && in_ready;
        if (fired) q.push_back({w, ref_conv(w)});
    endtask

    task automatic push(input logic [31:0] w);
        do step(1'b1, w, 1'($urandom_range(0, 9) < 7)); while (!fired);
    endtask

    function automatic logic [31:0] pick_word();
        logic [31:0] r;
        r = $urandom;
        case ($urandom_range(0, 7))
            1: r[30:23] = 8'hFF;
            2: r[15:0]  = 16'h8000;
            3: r[15:0]  = 16'h7FFF + 16'($urandom_range(0, 2));
            4: r[30:16] = 15'h7F7F;
            5: r[30:23] = 8'h00;
            default: ;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    localparam int NDIR = 18;
    logic [31:0] dir_vec [NDIR] = '{
        32'h3F800000, 32'h41200000, 32'h7F800001, 32'hFFC12345,
        32'h3F808000, 32'h3F818000, 32'h7F800000, 32'hFF800000,
        32'h7F7FFFFF, 32'hFF7FFFFF, 32'h80000000, 32'h00008000,
        32'h00008001, 32'h00018000, 32'h00000000, 32'h7FFFFFFF,
        32'h3F807FFF, 32'h3F808001
    };

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_word = '0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check(!out_valid, "R1", "out_valid in reset", 32'(out_valid), 0);
        check(in_ready, "R3", "in_ready empty", 32'(in_ready), 1);
        rst = 1'b0;

        // Directed corners, fully drained between each
        foreach (dir_vec[i]) begin
            push(dir_vec[i]);
            while (q.size() != 0) step(1'b0, '0, 1'b1);
        end
        // Back-to-back refill with a tie and a signalling NaN
        step(1'b1, 32'h3F808000, 1'b1);
        step(1'b1, 32'h7F800001, 1'b1);
        step(1'b1, 32'h7F7FFFFF, 1'b1);
        step(1'b0, '0, 1'b0);
        step(1'b0, '0, 1'b1);

        // Reset while a result is held
        step(1'b1, 32'h12345678, 1'b0);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; in_word = 32'h3F800000; out_ready = 1'b0;
        @(negedge clk); #1;
        check(!out_valid, "R1", "out_valid after reset", 32'(out_valid), 0);
        q.delete();
        hold_pend = 1'b0;
        rst = 1'b0; in_valid = 1'b0;

        // Random traffic with random backpressure
        for (int n = 0; n < 10000; ) begin
            logic [31:0] w;
            w = pick_word();
            step(1'($urandom_range(0, 3) != 0), w, 1'($urandom_range(0, 9) < 7));
            if (fired) n++;
        end
        while (q.size() != 0) step(1'b0, '0, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule